// File: doc/BRIEF.md
# Infrared Transmit Modulator

This block produces the drive level for an infrared emitter. The level it drives comes from one of three sources. The first is a queue of timed mark/space descriptors pushed by firmware. The second is a single software bit. The third is the serial output of a UART transmitter, where a low line counts as a mark.

In modulated mode, every mark is gated with a programmable carrier. The carrier is set by a period and a high time, both counted in system clocks, and it restarts whenever a space turns into a mark. In unmodulated mode, the mark level drives the pin directly. Descriptor durations are counted in ticks of `TICK_CLKS` system clocks, so with a tick of one microsecond a descriptor covers up to 32767 µs.

The control is a three-state machine:

- **ST_IDLE** drives a space.
- **ST_PLAY** runs the descriptor queue.
- **ST_FOLLOW** tracks the software bit or the UART line.

The transitions are:

- *start_play*: from ST_IDLE to ST_PLAY, taken when descriptors are selected and the queue holds data.
- *follow*: from ST_IDLE to ST_FOLLOW, taken when the bit or the UART source is selected.
- *drained*: from ST_PLAY to ST_IDLE, taken when a segment ends and the queue is empty.
- *unfollow*: from ST_FOLLOW to ST_IDLE, taken when neither live source is selected any more.
- *chain*: ST_PLAY stays in ST_PLAY, loading the next descriptor in the same cycle the current one ends.

Top module: `irtx_modulator`

## Requirements
- R1: After reset, ir_tx, busy and done are 0, fifo_empty is 1 and desc_full is 0.
- R2: A descriptor is a level bit plus a 15-bit tick count. Descriptors play in push order, back to back, each holding its level for count × TICK_CLKS clocks. A count of 0 plays as 1 tick.
- R3: desc_full is 1 when FIFO_DEPTH descriptors are queued. A push while desc_full is 1 is dropped and never played.
- R4: With cfg_modulate = 1, a mark drives the carrier. The carrier is high for the first cfg_car_high clocks of every cfg_car_period clocks, counted from the first clock of each mark. A high time of 0 gives a constant low. A high time at or above the period gives a constant high. A period of 0 or 1 acts as 1.
- R5: With cfg_modulate = 0, ir_tx equals the mark level.
- R6: ir_tx is registered. It reflects the selected source level one clock later, and a space always gives ir_tx = 0.
- R7: When a segment ends with the queue empty, the output drops to a space, busy falls and done rises. done clears when the next playback starts.
- R8: cfg_src_sel encodes the source: 0 is descriptors, 1 is the software bit, 2 is the UART line, 3 is off (always a space).
- R9: With source 1 selected and the block not busy, the mark level equals sw_level.
- R10: With source 2 selected and the block not busy, a low uart_txd is a mark and a high uart_txd is a space.
- R11: A change of cfg_src_sel while busy has no effect until the queue has drained. The new selection takes effect after that.
- R12: Playback starts when source 0 is selected while the queue is non-empty. busy stays 1 until the queue drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_sel | input | 2 | Source select (0 descriptors, 1 software bit, 2 UART, 3 off) |
| cfg_modulate | input | 1 | 1 gates marks with the carrier |
| cfg_car_period | input | CAR_W | Carrier period in clocks |
| cfg_car_high | input | CAR_W | Carrier high time in clocks |
| sw_level | input | 1 | Software-controlled level |
| uart_txd | input | 1 | UART serial output, low means mark |
| desc_push | input | 1 | Push one descriptor |
| desc_level | input | 1 | Level of pushed descriptor |
| desc_ticks | input | 15 | Duration of pushed descriptor in ticks |
| desc_full | output | 1 | Descriptor queue full |
| fifo_empty | output | 1 | Descriptor queue empty |
| busy | output | 1 | Descriptor playback in progress |
| done | output | 1 | Last playback drained the queue |
| ir_tx | output | 1 | Infrared drive output |

## Verification
The bench builds the block with TICK_CLKS = 3, FIFO_DEPTH = 4 and CAR_W = 8. The short tick keeps whole descriptor sequences, including zero-length ones, within a few dozen clocks, so every cycle of every segment can be compared. The shallow queue makes the full flag and the dropped push reachable with only five pushes. The narrow carrier fields let random periods and high times cover the degenerate cases: period 0 or 1, high time 0, and high time at or above the period.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int DUR_W = 15;

    typedef enum logic [1:0] {
        SRC_DESC = 2'd0,
        SRC_SOFT = 2'd1,
        SRC_UART = 2'd2,
        SRC_OFF  = 2'd3
    } irtx_src_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PLAY   = 2'd1,
        ST_FOLLOW = 2'd2
    } irtx_state_e;

    typedef struct packed {
        logic             level;
        logic [DUR_W-1:0] ticks;
    } irtx_desc_t;

endpackage

// File: rtl/irtx_desc_fifo.sv
module irtx_desc_fifo
    import irtx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  irtx_desc_t wdata,
    input  logic       pop,
    output irtx_desc_t head,
    output logic       full,
    output logic       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    irtx_desc_t      mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push;
    logic            do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: a push into a full queue leaves the fill level untouched
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // R12: the sequencer only pops when data is present
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mark,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] high_time,
    output logic          car_on
);
    logic [CW-1:0] phase;
    logic [CW:0]   phase_nxt;

    assign phase_nxt = {1'b0, phase} + 1'b1;
    assign car_on    = mark && (phase < high_time);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!mark) begin
            phase <= '0;
        end else if (phase_nxt >= {1'b0, period}) begin
            phase <= '0;
        end else begin
            phase <= phase_nxt[CW-1:0];
        end
    end

    // R4: the first clock of each mark begins a whole carrier pulse
    a_r4_first_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mark) && (high_time != '0)) |-> car_on);

    // R4: during a space the carrier is idle
    a_r4_space_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mark |-> !car_on);

endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
#(
    parameter int TICK_CLKS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       sw_level,
    input  logic       uart_txd,
    input  irtx_desc_t head,
    input  logic       fifo_empty,
    output logic       pop,
    output logic       mark,
    output logic       busy,
    output logic       done
);
    localparam int TW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CLKS - 1);

    irtx_state_e      state, state_nxt;
    logic             level_q;
    logic [DUR_W-1:0] remain;
    logic [TW-1:0]    tick_q;
    logic             done_q;
    logic             tick_wrap;
    logic             seg_end;
    logic             start_play;
    logic             load;
    logic             live_src;

    assign live_src   = (src_sel == SRC_SOFT) || (src_sel == SRC_UART);
    assign tick_wrap  = (tick_q == TICK_LAST);
    assign seg_end    = (state == ST_PLAY) && tick_wrap && (remain == 1);
    assign start_play = (state == ST_IDLE) && (src_sel == SRC_DESC) && !fifo_empty;
    assign load       = start_play || (seg_end && !fifo_empty);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_play)    state_nxt = ST_PLAY;    // start_play
                else if (live_src) state_nxt = ST_FOLLOW;  // follow
            end
            ST_PLAY: begin
                if (seg_end && fifo_empty) state_nxt = ST_IDLE;  // drained
            end
            ST_FOLLOW: begin
                if (!live_src) state_nxt = ST_IDLE;  // unfollow
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            level_q <= 1'b0;
            remain  <= '0;
            tick_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (load) begin
                level_q <= head.level;
                remain  <= (head.ticks == '0) ? DUR_W'(1) : head.ticks;
                tick_q  <= '0;
            end else if (state == ST_PLAY) begin
                if (tick_wrap) begin
                    tick_q <= '0;
                    remain <= remain - 1'b1;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
            if (start_play) begin
                done_q <= 1'b0;
            end else if (seg_end && fifo_empty) begin
                done_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mark = 1'b0;
        unique case (state)
            ST_PLAY:   mark = level_q;
            ST_FOLLOW: begin
                if (src_sel == SRC_SOFT)      mark = sw_level;
                else if (src_sel == SRC_UART) mark = !uart_txd;
                else                          mark = 1'b0;
            end
            default:   mark = 1'b0;
        endcase
    end

    assign busy = (state == ST_PLAY);
    assign done = done_q;
    assign pop  = load;

    // R11: playback is not left before its queue drains, whatever the select
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PLAY) && !seg_end) |=> (state == ST_PLAY));

    // R7: done and busy never overlap
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: playback only begins with queued data
    a_r12_start_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!fifo_empty));

    // R2: an active segment always has ticks left
    a_r2_remain_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain != '0));

endmodule

// File: rtl/irtx_modulator.sv
module irtx_modulator
    import irtx_pkg::*;
#(
    parameter int TICK_CLKS  = 100,
    parameter int FIFO_DEPTH = 8,
    parameter int CAR_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_src_sel,
    input  logic             cfg_modulate,
    input  logic [CAR_W-1:0] cfg_car_period,
    input  logic [CAR_W-1:0] cfg_car_high,
    input  logic             sw_level,
    input  logic             uart_txd,
    input  logic             desc_push,
    input  logic             desc_level,
    input  logic [14:0]      desc_ticks,
    output logic             desc_full,
    output logic             fifo_empty,
    output logic             busy,
    output logic             done,
    output logic             ir_tx
);
    irtx_desc_t wdesc;
    irtx_desc_t head;
    logic       pop;
    logic       mark;
    logic       car_on;
    logic       ir_q;

    assign wdesc.level = desc_level;
    assign wdesc.ticks = desc_ticks;

    irtx_desc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (desc_push),
        .wdata (wdesc),
        .pop   (pop),
        .head  (head),
        .full  (desc_full),
        .empty (fifo_empty)
    );

    irtx_seq #(.TICK_CLKS(TICK_CLKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (cfg_src_sel),
        .sw_level   (sw_level),
        .uart_txd   (uart_txd),
        .head       (head),
        .fifo_empty (fifo_empty),
        .pop        (pop),
        .mark       (mark),
        .busy       (busy),
        .done       (done)
    );

    irtx_carrier #(.CW(CAR_W)) u_car (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark      (mark),
        .period    (cfg_car_period),
        .high_time (cfg_car_high),
        .car_on    (car_on)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= 1'b0;
        else        ir_q <= mark && (!cfg_modulate || car_on);
    end

    assign ir_tx = ir_q;

    // R6: a space yields a low output one clock later
    a_r6_space_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mark |=> !ir_tx);

    // R5: unmodulated marks pass straight through one clock later
    a_r5_plain_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (mark && !cfg_modulate) |=> ir_tx);

endmodule

// File: tb/irtx_modulator_tb_top.sv
module irtx_modulator_tb_top;
    localparam int TICK  = 3;
    localparam int DEPTH = 4;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_src_sel = 2'd1;
    logic          cfg_modulate = 1'b0;
    logic [CW-1:0] cfg_car_period = 8'd4;
    logic [CW-1:0] cfg_car_high = 8'd2;
    logic          sw_level = 1'b0;
    logic          uart_txd = 1'b1;
    logic          desc_push = 1'b0;
    logic          desc_level = 1'b0;
    logic [14:0]   desc_ticks = '0;
    logic          desc_full, fifo_empty, busy, done, ir_tx;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    bit q_lvl [DEPTH];
    int q_dur [DEPTH];
    int q_n = 0;

    always #2 clk = ~clk;

    irtx_modulator #(.TICK_CLKS(TICK), .FIFO_DEPTH(DEPTH), .CAR_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_src_sel(cfg_src_sel), .cfg_modulate(cfg_modulate),
        .cfg_car_period(cfg_car_period), .cfg_car_high(cfg_car_high), .sw_level(sw_level),
        .uart_txd(uart_txd), .desc_push(desc_push), .desc_level(desc_level),
        .desc_ticks(desc_ticks), .desc_full(desc_full), .fifo_empty(fifo_empty),
        .busy(busy), .done(done), .ir_tx(ir_tx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected carrier level for a mark at the given phase (R4)
    function automatic bit exp_car(input int phase);
        return phase < int'(cfg_car_high);
    endfunction

    function automatic int next_phase(input int phase);
        return (phase + 1 >= int'(cfg_car_period)) ? 0 : phase + 1;
    endfunction

    task automatic push_desc(input bit lvl, input int dur);
        desc_push  = 1'b1;
        desc_level = lvl;
        desc_ticks = 15'(dur);
        @(negedge clk);
        desc_push  = 1'b0;
        if (q_n < DEPTH) begin
            q_lvl[q_n] = lvl;
            q_dur[q_n] = dur;
            q_n++;
        end
    endtask

    // precondition: software source selected with sw_level 0, at a negedge
    task automatic play_check(input string tag, input bit swap_src);
        int pos = 0;
        int phase = 0;
        int total = 0;
        for (int i = 0; i < q_n; i++) total += ((q_dur[i] == 0) ? 1 : q_dur[i]) * TICK;
        cfg_src_sel = 2'd0;
        repeat (3) @(negedge clk);
        check(busy === 1'b1, {tag, " R12 busy at start"}, busy, 1);
        check(done === 1'b0, {tag, " R7 done cleared"}, done, 0);
        for (int i = 0; i < q_n; i++) begin
            int d = (q_dur[i] == 0) ? 1 : q_dur[i];
            for (int k = 0; k < d * TICK; k++) begin
                bit e;
                if (!q_lvl[i]) begin
                    e = 1'b0;
                    phase = 0;
                end else begin
                    e = cfg_modulate ? exp_car(phase) : 1'b1;
                    phase = next_phase(phase);
                end
                check(ir_tx === e, {tag, " R2 R4 R5 waveform"}, ir_tx, e);
                if (swap_src && pos == total / 2) begin
                    cfg_src_sel = 2'd1;   // R11: ignored while busy
                    sw_level = 1'b1;
                end
                pos++;
                @(negedge clk);
            end
        end
        check(ir_tx === 1'b0, {tag, " R7 idle low"}, ir_tx, 0);
        check(busy === 1'b0, {tag, " R7 busy low"}, busy, 0);
        check(done === 1'b1, {tag, " R7 done set"}, done, 1);
        if (swap_src) begin
            bit e = !cfg_modulate || (cfg_car_high != 0);
            @(negedge clk);
            check(ir_tx === e, {tag, " R11 new source after drain"}, ir_tx, e);
        end
        cfg_src_sel = 2'd1;
        sw_level = 1'b0;
        q_n = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ir_tx === 1'b0, "R1 ir_tx", ir_tx, 0);
        check(busy === 1'b0, "R1 busy", busy, 0);
        check(done === 1'b0, "R1 done", done, 0);
        check(fifo_empty === 1'b1, "R1 fifo_empty", fifo_empty, 1);
        check(desc_full === 1'b0, "R1 desc_full", desc_full, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 software bit, unmodulated, one clock of latency (R6)
        sw_level = 1'b1;
        @(negedge clk);
        check(ir_tx === 1'b1, "R9 R6 soft high", ir_tx, 1);
        sw_level = 1'b0;
        @(negedge clk);
        check(ir_tx === 1'b0, "R9 soft low", ir_tx, 0);

        // R4 modulated soft mark, then restart after a space
        cfg_modulate = 1'b1;
        cfg_car_period = 8'd4;
        cfg_car_high = 8'd2;
        for (int rep = 0; rep < 2; rep++) begin
            sw_level = 1'b1;
            for (int j = 0; j < 7; j++) begin
                @(negedge clk);
                check(ir_tx === ((j % 4) < 2), "R4 carrier phase", ir_tx, (j % 4) < 2);
            end
            sw_level = 1'b0;
            @(negedge clk);
        end
        cfg_modulate = 1'b0;

        // R10 UART source: low is mark
        cfg_src_sel = 2'd2;
        uart_txd = 1'b0;
        @(negedge clk);
        check(ir_tx === 1'b1, "R10 uart low is mark", ir_tx, 1);
        uart_txd = 1'b1;
        @(negedge clk);
        check(ir_tx === 1'b0, "R10 uart high is space", ir_tx, 0);

        // R8 source 3 is off
        cfg_src_sel = 2'd1;
        sw_level = 1'b1;
        @(negedge clk);
        cfg_src_sel = 2'd3;
        @(negedge clk);
        check(ir_tx === 1'b0, "R8 off source", ir_tx, 0);
        @(negedge clk);
        check(ir_tx === 1'b0, "R8 off source held", ir_tx, 0);
        cfg_src_sel = 2'd1;
        sw_level = 1'b0;
        repeat (2) @(negedge clk);

        // R3 full queue drops the extra push
        push_desc(1'b1, 2);
        push_desc(1'b0, 1);
        push_desc(1'b1, 0);
        push_desc(1'b0, 2);
        check(desc_full === 1'b1, "R3 full flag", desc_full, 1);
        push_desc(1'b1, 5);
        check(desc_full === 1'b1, "R3 still full", desc_full, 1);
        play_check("directed_full", 1'b0);

        // R11 source change while busy
        cfg_modulate = 1'b1;
        cfg_car_period = 8'd3;
        cfg_car_high = 8'd1;
        push_desc(1'b1, 3);
        push_desc(1'b1, 2);
        push_desc(1'b0, 1);
        push_desc(1'b1, 1);
        play_check("directed_swap", 1'b1);

        // random mix
        for (int it = 0; it < 30; it++) begin
            int n = 1 + int'($urandom % DEPTH);
            cfg_modulate = 1'($urandom % 2);
            cfg_car_period = CW'($urandom % 7);
            cfg_car_high = CW'($urandom % 8);
            for (int i = 0; i < n; i++) push_desc(1'($urandom % 2), int'($urandom % 6));
            play_check("random", (it % 3) == 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule